// File: doc/BRIEF.md
# MDIO Command-Word Management Master

This block runs clause-22 PHY management transactions on an MDC/MDIO pair. Software starts a transaction with a single 32-bit command word. The word carries the PHY address, the register address, one request bit for a read or a write, and 16 data bits for writes. The block then shifts out the complete management frame with no further software involvement. Software polls the completion flag in the same word. After a read, the 16 low bits of that word hold the value returned by the PHY.

The bidirectional MDIO line is modelled as three signals: an output value, an output enable and an input. MDC is generated internally. Every frame bit takes three equal phases: low, high, low. Each phase lasts `PHASE_CYC` clock cycles, which gives about 1 µs per phase at the default setting. MDIO changes only while MDC is low, and read data is sampled during the high phase.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `cmd_rdata` reads 0, MDC is low and the MDIO output enable is low.
- R2: A write of `cmd_wdata` while idle, with exactly one request bit set, starts a frame. The request bits are bit 26 (write) and bit 27 (read). The PHY address is in bits 25:21 and the register address in bits 20:16. The completion flag (bit 28) reads 0 from the cycle after the write, and the address and request fields read back as written.
- R3: Every frame begins with 35 one bits, driven with the output enable high.
- R4: After the preamble come the start bits 0 then 1, followed by the opcode: 1,0 for a read and 0,1 for a write.
- R5: The PHY address follows the opcode, then the register address. Each is 5 bits, sent most significant bit first, with the output enable high.
- R6: A write frame ends with the turnaround bits 1 then 0, then the 16 data bits from bits 15:0, most significant first. The output enable stays high throughout.
- R7: In a read frame the output enable goes low after the register address and stays low for one turnaround bit and 16 data bits. The input is sampled while MDC is high, most significant bit first, and the result is placed in bits 15:0 when the completion flag sets.
- R8: Each bit is one MDC pulse: low, then high, then low, with each phase `PHASE_CYC` cycles long. MDIO output and output enable never change while MDC is high.
- R9: The completion flag sets only after the last bit of the frame has finished. After a write, bits 15:0 keep the data that was written.
- R10: A command word with both request bits set, or with neither set, produces no MDC pulse. Its completion flag reads 1 from the cycle after the write.
- R11: A command write that arrives during a frame is ignored. The register does not change and the running frame completes unchanged.
- R12: Whenever no frame is in progress, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Command/status word read back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Some properties are checked on every cycle by the assertions:
- the line is held still while MDC is high;
- the bus is released when idle and during the read data phase;
- the phase counter stays in range;
- the completion flag clears on acceptance and sets on frame end or on a no-op word;
- the register stays frozen while a frame runs.

Other behaviour can only be shown by the bench scenarios. These cover the bit-for-bit content of each frame against a frame built independently in the bench, and the exact length of the high phase. They also cover the PHY returning data that ends up in the low half of the word, and a mid-frame command write that leaves the running transaction untouched.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  // command word field positions
  localparam int F_DATA_LSB = 0;
  localparam int F_REG_LSB  = 16;
  localparam int F_PHY_LSB  = 21;
  localparam int F_WR       = 26;
  localparam int F_RD       = 27;
  localparam int F_DONE     = 28;

  // frame geometry, in bits
  localparam int PRE_BITS  = 35;
  localparam int HDR_BITS  = PRE_BITS + 2 + 2 + 5 + 5;   // 49
  localparam int DATA_BITS = 16;
  localparam int WR_FRAME  = HDR_BITS + 2 + DATA_BITS;   // 67
  localparam int RD_FRAME  = HDR_BITS + 1 + DATA_BITS;   // 66
  localparam int IDX_W     = 7;

  typedef enum logic [1:0] {
    PH_LO1 = 2'd0,
    PH_HI  = 2'd1,
    PH_LO2 = 2'd2
  } phase_e;

  typedef struct packed {
    logic        is_wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } xfer_t;

  function automatic logic [IDX_W-1:0] frame_len(input logic is_wr);
    return is_wr ? IDX_W'(WR_FRAME) : IDX_W'(RD_FRAME);
  endfunction

  // output enable for bit position idx
  function automatic logic drive_en(input logic [IDX_W-1:0] idx, input logic is_wr);
    return (int'(idx) < HDR_BITS) || is_wr;
  endfunction

  // read frames sample the line during these bit positions
  function automatic logic is_sample(input logic [IDX_W-1:0] idx, input logic is_wr);
    return !is_wr && (int'(idx) > HDR_BITS) && (int'(idx) < RD_FRAME);
  endfunction

  // value driven on MDIO for bit position idx of transfer x
  function automatic logic frame_bit(input logic [IDX_W-1:0] idx, input xfer_t x);
    int          i;
    logic [4:0]  f5;
    logic [15:0] f16;
    i = int'(idx);
    f5 = '0;
    f16 = '0;
    if (i < PRE_BITS)        return 1'b1;
    else if (i == PRE_BITS)      return 1'b0;
    else if (i == PRE_BITS + 1)  return 1'b1;
    else if (i == PRE_BITS + 2)  return !x.is_wr;
    else if (i == PRE_BITS + 3)  return x.is_wr;
    else if (i < PRE_BITS + 9) begin
      f5 = x.phy >> (PRE_BITS + 8 - i);
      return f5[0];
    end else if (i < HDR_BITS) begin
      f5 = x.regad >> (HDR_BITS - 1 - i);
      return f5[0];
    end else if (i == HDR_BITS)      return 1'b1;
    else if (i == HDR_BITS + 1)  return 1'b0;
    else begin
      f16 = x.wdata >> (WR_FRAME - 1 - i);
      return f16[0];
    end
  endfunction

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen
  import mdio_cmd_pkg::*;
#(
  parameter int PHASE_CYC = 50
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  output phase_e phase,
  output logic   sample_now,
  output logic   bit_done
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end  = (cnt == CNT_LAST);
  assign sample_now = run && (phase == PH_HI)  && phase_end;
  assign bit_done   = run && (phase == PH_LO2) && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= PH_LO1;
    end else if (phase_end) begin
      cnt <= '0;
      case (phase)
        PH_LO1:  phase <= PH_HI;
        PH_HI:   phase <= PH_LO2;
        default: phase <= PH_LO1;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < PHASE_CYC);

  p_phase_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

endmodule

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_t       start_x,
  input  phase_e      phase,
  input  logic        sample_now,
  input  logic        bit_done,
  input  logic        mdio_i,
  output logic        busy,
  output logic        fin,
  output logic [15:0] rd_val,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [IDX_W-1:0] idx;
  xfer_t            x;
  logic [15:0]      shreg;
  logic             last_bit;

  assign last_bit = (idx == frame_len(x.is_wr) - 1'b1);
  assign fin      = busy && bit_done && last_bit;
  assign rd_val   = shreg;
  assign mdc      = busy && (phase == PH_HI);
  assign mdio_oe  = busy && drive_en(idx, x.is_wr);
  assign mdio_o   = mdio_oe && frame_bit(idx, x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      x     <= '0;
      shreg <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      x     <= start_x;
      shreg <= '0;
    end else if (busy) begin
      if (sample_now && is_sample(idx, x.is_wr))
        shreg <= {shreg[14:0], mdio_i};
      if (bit_done) begin
        if (last_bit) busy <= 1'b0;
        else          idx  <= idx + 1'b1;
      end
    end
  end

  p_hold_while_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o) && $stable(mdio_oe));

  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !x.is_wr && int'(idx) >= HDR_BITS) |-> !mdio_oe);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < frame_len(x.is_wr)));

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int PHASE_CYC = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0] cmd_q;
  logic        busy, fin;
  logic [15:0] rd_val;
  logic        one_req, accept, noop;
  xfer_t       sx;
  phase_e      phase;
  logic        sample_now, bit_done;

  assign one_req = cmd_wdata[F_WR] ^ cmd_wdata[F_RD];
  assign accept  = cmd_we && !busy && one_req;
  assign noop    = cmd_we && !busy && !one_req;

  assign sx.is_wr = cmd_wdata[F_WR];
  assign sx.phy   = cmd_wdata[F_PHY_LSB +: 5];
  assign sx.regad = cmd_wdata[F_REG_LSB +: 5];
  assign sx.wdata = cmd_wdata[F_DATA_LSB +: 16];

  assign cmd_rdata = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q         <= cmd_wdata;
      cmd_q[F_DONE] <= 1'b0;
    end else if (noop) begin
      cmd_q         <= cmd_wdata;
      cmd_q[F_DONE] <= 1'b1;
    end else if (fin) begin
      cmd_q[F_DONE] <= 1'b1;
      if (cmd_q[F_RD]) cmd_q[F_DATA_LSB +: 16] <= rd_val;
    end
  end

  mdio_phase_gen #(.PHASE_CYC(PHASE_CYC)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .phase      (phase),
    .sample_now (sample_now),
    .bit_done   (bit_done)
  );

  mdio_bit_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_x    (sx),
    .phase      (phase),
    .sample_now (sample_now),
    .bit_done   (bit_done),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .fin        (fin),
    .rd_val     (rd_val),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  p_accept_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!cmd_rdata[F_DONE] && busy));

  p_noop_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    noop |=> (cmd_rdata[F_DONE] && !busy && !mdc));

  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(cmd_rdata));

  p_fin_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (cmd_rdata[F_DONE] && !busy));

  p_done_low_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_rdata[F_DONE]);

endmodule

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_cmd_master #(.PHASE_CYC(PH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [1:0]  exp_q[$];      // {oe, value}
  logic [15:0] resp_word = '0;
  bit          cur_is_wr = 1'b0;
  int          frame_id = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    if (k < 35) return "R3 preamble";
    if (k < 39) return "R4 start/opcode";
    if (k < 49) return "R5 address";
    return cur_is_wr ? "R6 write tail" : "R7 read release";
  endfunction

  // monitor: one compare per MDC rising edge
  logic prev_mdc = 1'b0;
  int   rise_cnt = 0;
  int   seen_id = 0;
  int   hi_len = 0;
  bit   moved = 0;
  logic hold_o = 1'b0, hold_oe = 1'b0;
  logic [1:0] item;

  always @(negedge clk) begin
    if (frame_id != seen_id) begin
      seen_id  = frame_id;
      rise_cnt = 0;
    end
    if (mdc && !prev_mdc) begin
      hi_len = 1; moved = 0; hold_o = mdio_o; hold_oe = mdio_oe;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected MDC pulse", rise_cnt, 0);
      end else begin
        item = exp_q.pop_front();
        check(mdio_oe == item[1], {tag_of(rise_cnt), " oe"}, mdio_oe, item[1]);
        if (item[1])
          check(mdio_o == item[0], {tag_of(rise_cnt), " value"}, mdio_o, item[0]);
      end
      rise_cnt++;
    end else if (mdc && prev_mdc) begin
      hi_len++;
      if (mdio_o !== hold_o || mdio_oe !== hold_oe) moved = 1;
    end else if (!mdc && prev_mdc) begin
      check(hi_len == PH, "R8 high phase length", hi_len, PH);
      check(!moved, "R8 line stable while MDC high", moved, 0);
      if (rise_cnt >= 50 && rise_cnt <= 65) mdio_i = resp_word[65 - rise_cnt];
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic push_frame(input bit w, input logic [4:0] p,
                            input logic [4:0] r, input logic [15:0] d);
    logic [13:0] hdr;
    logic [17:0] tl;
    for (int k = 0; k < 35; k++) exp_q.push_back(2'b11);
    hdr = {2'b01, (w ? 2'b01 : 2'b10), p, r};
    for (int k = 13; k >= 0; k--) exp_q.push_back({1'b1, hdr[k]});
    if (w) begin
      tl = {2'b10, d};
      for (int k = 17; k >= 0; k--) exp_q.push_back({1'b1, tl[k]});
    end else begin
      for (int k = 0; k < 17; k++) exp_q.push_back(2'b00);
    end
  endtask

  task automatic launch(input bit w, input bit rd, input logic [4:0] p,
                        input logic [4:0] r, input logic [15:0] d);
    logic [31:0] word;
    word = '0;
    word[27] = rd; word[26] = w;
    word[25:21] = p; word[20:16] = r; word[15:0] = d;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = word;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!cmd_rdata[28] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(cmd_rdata[28], "R9 completion flag set", cmd_rdata[28], 1);
  endtask

  task automatic finish_checks(input bit w, input logic [4:0] p,
                               input logic [4:0] r, input logic [15:0] d,
                               input logic [15:0] resp);
    check(exp_q.size() == 0, "R9 every bit sent before done", exp_q.size(), 0);
    check(!mdc && !mdio_oe, "R12 idle after frame", {mdc, mdio_oe}, 0);
    check(cmd_rdata[25:21] == p && cmd_rdata[20:16] == r, "R2 address readback",
          cmd_rdata[25:16], {p, r});
    check(cmd_rdata[27:26] == {!w, w}, "R2 request readback", cmd_rdata[27:26], {!w, w});
    if (w) check(cmd_rdata[15:0] == d, "R9 write data kept", cmd_rdata[15:0], d);
    else   check(cmd_rdata[15:0] == resp, "R7 read data captured", cmd_rdata[15:0], resp);
  endtask

  task automatic run_cmd(input bit w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [15:0] resp);
    cur_is_wr = w;
    resp_word = resp;
    frame_id++;
    push_frame(w, p, r, d);
    launch(w, !w, p, r, d);
    check(!cmd_rdata[28], "R2 done cleared on accept", cmd_rdata[28], 0);
    wait_done();
    finish_checks(w, p, r, d, resp);
  endtask

  task automatic run_noop(input bit both);
    launch(both, both, 5'd3, 5'd4, 16'hBEEF);
    check(cmd_rdata[28], "R10 no-op done next cycle", cmd_rdata[28], 1);
    repeat (40) @(negedge clk);
    check(!mdc && !mdio_oe, "R10 no frame on no-op", {mdc, mdio_oe}, 0);
    check(cmd_rdata[15:0] == 16'hBEEF, "R10 no-op word stored", cmd_rdata[15:0], 16'hBEEF);
  endtask

  logic [31:0] saved;

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_rdata == 0, "R1 reset word", cmd_rdata, 0);
    check(!mdc && !mdio_oe, "R1 reset line", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!mdc && !mdio_oe, "R12 idle before use", {mdc, mdio_oe}, 0);

    run_cmd(1'b1, 5'd1,  5'd0,  16'h8000, 16'h0);
    run_cmd(1'b1, 5'd31, 5'd31, 16'hA5C3, 16'h0);
    run_cmd(1'b0, 5'h12, 5'd3,  16'h0,    16'h1234);
    run_cmd(1'b0, 5'h15, 5'h0A, 16'h0,    16'h8001);
    run_cmd(1'b0, 5'd0,  5'd0,  16'hFFFF, 16'h0000);

    run_noop(1'b1);
    run_noop(1'b0);

    // R11: a command written mid-frame is dropped
    cur_is_wr = 1'b1;
    resp_word = 16'h0;
    frame_id++;
    push_frame(1'b1, 5'h0B, 5'h11, 16'h5A0F);
    launch(1'b1, 1'b0, 5'h0B, 5'h11, 16'h5A0F);
    repeat (100) @(negedge clk);
    saved = cmd_rdata;
    launch(1'b0, 1'b1, 5'h02, 5'h04, 16'h1111);
    check(cmd_rdata == saved, "R11 mid-frame write ignored", cmd_rdata, saved);
    wait_done();
    finish_checks(1'b1, 5'h0B, 5'h11, 16'h5A0F, 16'h0);

    repeat (10) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule